// File: doc/BRIEF.md
# Warp memory access coalescer

This block sits between the address stage of a 32-lane SIMT memory pipeline and the memory subsystem. It takes one memory request for a whole warp at a time. The request holds an active mask, a byte address for every lane, one access size used by all lanes, an access kind (load, store or atomic) and an uncached flag. The block works out which aligned granules the active lanes touch: 128-byte lines for cached traffic and 32-byte segments for uncached traffic. It then sends one transaction per granule over a valid/ready channel.

Each transaction carries the granule base address, a byte mask inside the granule and a lane map. The return path uses the lane map to route data to the right lanes. Conflicts on a single address are settled by kind. Loads to one address share a single access, and every lane that asked receives the value. Stores to one address write the data of only one lane. Atomics are never combined and go out one lane at a time. A lane whose address is not a multiple of the access size is reported on an error output and produces no traffic.

Top module: `warp_coalescer`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `txn_valid` is 0 and `align_err` is 0.
- R2: For a cached request (`req_uncached`=0), each distinct 128-byte aligned line touched by the valid lanes produces exactly one transaction, with `txn_addr` equal to the line base. For example, 16 lanes reading 8 bytes each at 192, 200, …, 312 give two transactions, at 128 and 256.
- R3: For an uncached request, the granule is a 32-byte aligned segment instead. `txn_addr` is a multiple of 32, and only `txn_bytes[31:0]` can be set.
- R4: Transactions of one request leave in ascending order of the lowest valid lane that touches each granule. `txn_last` is 1 only on the final one.
- R5: `req_size` codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes per lane. `txn_bytes` bit b is 1 exactly when some lane of the granule covers byte `txn_addr`+b.
- R6: When `req_kind`=0 (load), all valid lanes in a granule are served by one transaction whose `txn_lanes` lists every one of them, including lanes that share one address.
- R7: When `req_kind`=1 (store) and several valid lanes hit the same address, only the highest-numbered of those lanes appears in `txn_lanes`.
- R8: When `req_kind`=2 or 3 (atomic), every valid lane produces its own transaction with exactly one bit set in `txn_lanes`, even when addresses or lines are shared.
- R9: Inactive lanes generate nothing. A request with no valid lane is accepted, produces no transaction, and leaves `req_ready` at 1.
- R10: An active lane whose address is not a multiple of the access size is dropped. In the cycle after acceptance, `align_err` is 1 and bit i of `align_err_lanes` marks each dropped lane i.
- R11: A transaction stays stable while `txn_valid`=1 and `txn_ready`=0. `req_ready` is 0 from the cycle after acceptance of a request that has valid lanes until the cycle after its last transaction is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 load, 1 store, 2 or 3 atomic |
| req_uncached | input | 1 | 1 selects 32-byte segments, 0 selects 128-byte lines |
| req_size | input | 3 | Access size code, bytes = 1 << code (codes above 4 mean 16) |
| req_mask | input | LANES | Active lanes |
| req_addr | input | LANES*AW | Lane i byte address in bits [i*AW +: AW] |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | AW | Granule base address |
| txn_kind | output | 2 | Kind of the originating request |
| txn_uncached | output | 1 | Granule is a 32-byte segment |
| txn_bytes | output | LINE_B | Byte mask within the granule |
| txn_lanes | output | LANES | Lanes that receive or supply data |
| txn_last | output | 1 | Final transaction of the request |
| align_err | output | 1 | One-cycle flag: some lane was misaligned |
| align_err_lanes | output | LANES | Misaligned lanes of the accepted request |

## Verification
On every cycle, the assertions check the channel rules: a transaction stalled by the downstream stays stable, no request is accepted while a transaction is pending, and `req_ready` returns after the last one is taken. They also check that granule addresses are aligned, that uncached byte masks stay inside the segment, that atomic transactions carry exactly one lane, and that an alignment error appears only right after an acceptance. The grouping itself depends on the whole set of lane addresses, so only the bench scenarios can show it: the number of transactions, their order, the exact byte masks, the merging of same-address loads and the choice of the store winner.

// File: rtl/wc_pkg.sv
package wc_pkg;

  typedef enum logic [1:0] {
    WC_LOAD   = 2'd0,
    WC_STORE  = 2'd1,
    WC_ATOM_A = 2'd2,
    WC_ATOM_B = 2'd3
  } wc_kind_e;

  // byte count for a size code; codes past 4 saturate at 16 bytes
  function automatic logic [4:0] wc_size_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  function automatic logic wc_is_atomic(input wc_kind_e k);
    return (k == WC_ATOM_A) || (k == WC_ATOM_B);
  endfunction

endpackage

// File: rtl/wc_align_check.sv
module wc_align_check #(
  parameter int LANES = 32,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES-1:0]    mask,
  input  logic [2:0]          size_code,
  output logic [LANES-1:0]    lane_ok,
  output logic [LANES-1:0]    lane_bad
);
  import wc_pkg::*;

  logic [AW-1:0] low_mask;
  assign low_mask = AW'(wc_size_bytes(size_code)) - AW'(1);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic misal;
    assign misal       = (addr_flat[i*AW +: AW] & low_mask) != '0;
    assign lane_ok[i]  = mask[i] && !misal;
    assign lane_bad[i] = mask[i] && misal;
  end

endmodule

// File: rtl/wc_group_select.sv
module wc_group_select #(
  parameter int LANES  = 32,
  parameter int AW     = 32,
  parameter int LINE_B = 128,
  parameter int SEG_B  = 32
) (
  input  logic [LANES-1:0]     pend,
  input  logic [LANES*AW-1:0]  addr_flat,
  input  wc_pkg::wc_kind_e     kind,
  input  logic                 uncached,
  input  logic [2:0]           size_code,
  output logic                 any,
  output logic [AW-1:0]        base,
  output logic [LANES-1:0]     lanes,
  output logic [LANES-1:0]     taken,
  output logic [LINE_B-1:0]    bytes
);
  import wc_pkg::*;

  localparam int LW       = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int LINE_OFF = $clog2(LINE_B);

  logic [AW-1:0]     la [LANES];
  logic [LW-1:0]     first;
  logic [AW-1:0]     gmask;
  logic [LANES-1:0]  grp;
  logic [LANES-1:0]  winners;
  logic [LINE_B-1:0] szm;
  logic [4:0]        nbytes;

  for (genvar i = 0; i < LANES; i++) begin : g_unpack
    assign la[i] = addr_flat[i*AW +: AW];
  end

  assign any    = pend != '0;
  assign gmask  = uncached ? AW'(SEG_B - 1) : AW'(LINE_B - 1);
  assign nbytes = wc_size_bytes(size_code);

  // lowest pending lane leads the next transaction
  always_comb begin
    first = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend[i]) first = LW'(i);
  end

  assign base = la[first] & ~gmask;

  for (genvar i = 0; i < LANES; i++) begin : g_grp
    assign grp[i] = pend[i] && ((la[i] & ~gmask) == base);
  end

  // a store lane loses when a higher lane of the group writes the same address
  always_comb begin
    winners = grp;
    for (int i = 0; i < LANES; i++)
      for (int j = i + 1; j < LANES; j++)
        if (grp[i] && grp[j] && (la[j] == la[i])) winners[i] = 1'b0;
  end

  always_comb begin
    taken = grp;
    lanes = grp;
    if (wc_is_atomic(kind)) begin
      taken = '0;
      taken[first] = 1'b1;
      lanes = taken;
    end else if (kind == WC_STORE) begin
      lanes = winners;
    end
  end

  always_comb begin
    szm = '0;
    for (int k = 0; k < 16; k++) szm[k] = (k < int'(nbytes));
    bytes = '0;
    for (int i = 0; i < LANES; i++)
      if (taken[i]) bytes = bytes | (szm << (la[i][LINE_OFF-1:0] & gmask[LINE_OFF-1:0]));
  end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES  = 32,
  parameter int AW     = 32,
  parameter int LINE_B = 128,
  parameter int SEG_B  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_kind,
  input  logic                 req_uncached,
  input  logic [2:0]           req_size,
  input  logic [LANES-1:0]     req_mask,
  input  logic [LANES*AW-1:0]  req_addr,
  output logic                 txn_valid,
  input  logic                 txn_ready,
  output logic [AW-1:0]        txn_addr,
  output logic [1:0]           txn_kind,
  output logic                 txn_uncached,
  output logic [LINE_B-1:0]    txn_bytes,
  output logic [LANES-1:0]     txn_lanes,
  output logic                 txn_last,
  output logic                 align_err,
  output logic [LANES-1:0]     align_err_lanes
);
  import wc_pkg::*;

  logic                busy;
  logic [LANES-1:0]    pend;
  logic [LANES*AW-1:0] addr_q;
  wc_kind_e            kind_q;
  logic                unc_q;
  logic [2:0]          size_q;

  logic [LANES-1:0]    ok_lanes, bad_lanes;
  logic                sel_any;
  logic [AW-1:0]       sel_base;
  logic [LANES-1:0]    sel_lanes, sel_taken;
  logic [LINE_B-1:0]   sel_bytes;

  logic accept, advance;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign advance   = busy && (!txn_valid || txn_ready);

  wc_align_check #(.LANES(LANES), .AW(AW)) u_align (
    .addr_flat (req_addr),
    .mask      (req_mask),
    .size_code (req_size),
    .lane_ok   (ok_lanes),
    .lane_bad  (bad_lanes)
  );

  wc_group_select #(.LANES(LANES), .AW(AW), .LINE_B(LINE_B), .SEG_B(SEG_B)) u_sel (
    .pend      (pend),
    .addr_flat (addr_q),
    .kind      (kind_q),
    .uncached  (unc_q),
    .size_code (size_q),
    .any       (sel_any),
    .base      (sel_base),
    .lanes     (sel_lanes),
    .taken     (sel_taken),
    .bytes     (sel_bytes)
  );

  // request capture and error reporting
  always_ff @(posedge clk) begin
    if (rst) begin
      busy            <= 1'b0;
      pend            <= '0;
      align_err       <= 1'b0;
      align_err_lanes <= '0;
    end else begin
      align_err       <= accept && (bad_lanes != '0);
      align_err_lanes <= accept ? bad_lanes : '0;
      if (accept) begin
        pend <= ok_lanes;
        busy <= ok_lanes != '0;
      end else begin
        if (txn_valid && txn_ready && txn_last) busy <= 1'b0;
        if (advance && sel_any) pend <= pend & ~sel_taken;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
      kind_q <= wc_kind_e'(req_kind);
      unc_q  <= req_uncached;
      size_q <= req_size;
    end
  end

  // registered transaction output
  always_ff @(posedge clk) begin
    if (rst) begin
      txn_valid <= 1'b0;
      txn_last  <= 1'b0;
    end else if (advance && !accept) begin
      txn_valid <= sel_any;
      if (sel_any) begin
        txn_addr     <= sel_base;
        txn_kind     <= kind_q;
        txn_uncached <= unc_q;
        txn_bytes    <= sel_bytes;
        txn_lanes    <= sel_lanes;
        txn_last     <= (pend & ~sel_taken) == '0;
      end
    end
  end

endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES  = 32,
  parameter int AW     = 32,
  parameter int LINE_B = 128,
  parameter int SEG_B  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [AW-1:0]     txn_addr,
  input logic [1:0]        txn_kind,
  input logic              txn_uncached,
  input logic [LINE_B-1:0] txn_bytes,
  input logic [LANES-1:0]  txn_lanes,
  input logic              txn_last,
  input logic              align_err,
  input logic [LANES-1:0]  align_err_lanes
);
  localparam int SEG_OFF  = $clog2(SEG_B);
  localparam int LINE_OFF = $clog2(LINE_B);

  AST_TXN_HOLD: assert property (@(posedge clk) disable iff (rst)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_lanes) && $stable(txn_bytes)); // R11
  AST_NO_ACCEPT_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> !req_ready); // R11
  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    txn_valid && txn_ready && txn_last |=> req_ready && !txn_valid); // R11
  AST_ATOMIC_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    txn_valid && txn_kind[1] |-> $countones(txn_lanes) == 1); // R8
  AST_TXN_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> txn_lanes != '0 && txn_bytes != '0); // R5
  AST_SEG_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> txn_addr[SEG_OFF-1:0] == '0); // R3
  AST_SEG_BYTES_INSIDE: assert property (@(posedge clk) disable iff (rst)
    txn_valid && txn_uncached |-> txn_bytes[LINE_B-1:SEG_B] == '0); // R3
  AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    txn_valid && !txn_uncached |-> txn_addr[LINE_OFF-1:0] == '0); // R2
  AST_ERR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    align_err |-> $past(req_valid && req_ready) && align_err_lanes != '0); // R10

endmodule

bind warp_coalescer warp_coalescer_chk #(.LANES(LANES), .AW(AW), .LINE_B(LINE_B), .SEG_B(SEG_B)) u_chk (.*);

// File: tb/warp_coalescer_test.sv
module warp_coalescer_test;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic          req_uncached = 1'b0;
  logic [2:0]    req_size = 3'd0;
  logic [31:0]   req_mask = '0;
  logic [1023:0] req_addr;
  logic          txn_valid;
  logic          txn_ready = 1'b1;
  logic [31:0]   txn_addr;
  logic [1:0]    txn_kind;
  logic          txn_uncached;
  logic [127:0]  txn_bytes;
  logic [31:0]   txn_lanes;
  logic          txn_last;
  logic          align_err;
  logic [31:0]   align_err_lanes;

  always #2 clk = ~clk;   // 250 MHz

  warp_coalescer uut (.*);

  logic [31:0] a [32];
  always_comb for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = a[i];

  typedef struct {
    logic [31:0]  addr;
    logic [31:0]  lanes;
    logic [127:0] bytes;
    logic         last;
  } txn_t;

  txn_t        q[$];
  int          checks = 0;
  int          errors = 0;
  int          popped = 0;
  bit          fresh = 0;
  bit          stall_mode = 0;
  bit          model_on = 0;
  logic [31:0] m_err = '0;
  logic [31:0] seen_err = '0;
  logic [1:0]  m_kind = '0;
  logic        m_unc = 0;
  string       tag = "R1";

  task automatic check(input string r, input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // behavioural expectation for one accepted request
  task automatic build();
    int gran;
    int sz;
    logic [31:0] pend;
    gran = req_uncached ? 32 : 128;
    sz = (req_size >= 3'd4) ? 16 : (1 << req_size);
    pend = '0;
    m_err = '0;
    m_kind = req_kind;
    m_unc = req_uncached;
    for (int i = 0; i < 32; i++)
      if (req_mask[i]) begin
        if (a[i] % 32'(sz) == 0) pend[i] = 1'b1;
        else m_err[i] = 1'b1;
      end
    while (pend != '0) begin
      int lead;
      logic [31:0] base;
      logic [31:0] g;
      txn_t t;
      lead = -1;
      for (int i = 0; i < 32; i++) if (pend[i] && lead < 0) lead = i;
      base = a[lead] - a[lead] % 32'(gran);
      g = '0;
      for (int i = 0; i < 32; i++)
        if (pend[i] && (a[i] - a[i] % 32'(gran)) == base) g[i] = 1'b1;
      if (req_kind >= 2'd2) begin
        g = '0;
        g[lead] = 1'b1;
      end
      t.lanes = g;
      if (req_kind == 2'd1)
        for (int i = 0; i < 32; i++)
          for (int j = i + 1; j < 32; j++)
            if (g[i] && g[j] && a[i] == a[j]) t.lanes[i] = 1'b0;
      t.bytes = '0;
      for (int i = 0; i < 32; i++)
        if (g[i]) for (int b = 0; b < sz; b++) t.bytes[int'(a[i] - base) + b] = 1'b1;
      t.addr = base;
      pend = pend & ~g;
      t.last = (pend == '0);
      q.push_back(t);
    end
  endtask

  // reference model advanced on every clock
  always @(posedge clk) begin
    if (rst || !model_on) begin
      q.delete();
      fresh = 0;
      m_err = '0;
    end else begin
      fresh = 0;
      if (txn_valid && txn_ready && q.size() > 0) begin
        void'(q.pop_front());
        popped++;
      end
      if (req_valid && req_ready) begin
        build();
        fresh = 1;
      end else m_err = '0;
    end
  end

  // per-cycle comparison away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (model_on && !rst) begin
        seen_err |= align_err_lanes;
        check(tag, req_ready == (q.size() == 0), "req_ready", 128'(req_ready), 128'(q.size() == 0));
        check(tag, txn_valid == (q.size() > 0 && !fresh), "txn_valid", 128'(txn_valid), 128'(q.size() > 0 && !fresh));
        check("R10", align_err_lanes == m_err && align_err == (m_err != 0), "align_err_lanes", 128'(align_err_lanes), 128'(m_err));
        if (txn_valid && q.size() > 0) begin
          check(tag, txn_addr == q[0].addr, "txn_addr", 128'(txn_addr), 128'(q[0].addr));
          check(tag, txn_lanes == q[0].lanes, "txn_lanes", 128'(txn_lanes), 128'(q[0].lanes));
          check(tag, txn_bytes == q[0].bytes, "txn_bytes", txn_bytes, q[0].bytes);
          check(tag, txn_last == q[0].last, "txn_last", 128'(txn_last), 128'(q[0].last));
          check(tag, txn_kind == m_kind && txn_uncached == m_unc, "txn_kind/uncached",
                128'({txn_kind, txn_uncached}), 128'({m_kind, m_unc}));
        end
      end
    end
  end

  // downstream readiness, optionally stalling
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      txn_ready = stall_mode ? (((cyc >> 1) ^ cyc) & 1) == 1 : 1'b1;
    end
  end

  task automatic run(input string t, input logic [1:0] k, input logic u, input logic [2:0] s,
                     input logic [31:0] m, input int exp_n);
    int guard;
    tag = t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    popped = 0;
    seen_err = '0;
    req_kind = k;
    req_uncached = u;
    req_size = s;
    req_mask = m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while ((q.size() > 0 || fresh) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    check(t, popped == exp_n, "transaction count", 128'(popped), 128'(exp_n));
  endtask

  task automatic clear_addr();
    for (int i = 0; i < 32; i++) a[i] = 32'h0;
  endtask

  initial begin
    clear_addr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", req_ready == 1'b1, "req_ready in reset", 128'(req_ready), 128'(1));
    check("R1", txn_valid == 1'b0, "txn_valid in reset", 128'(txn_valid), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R1", req_ready && !txn_valid && !align_err, "state after reset",
          128'({req_ready, txn_valid, align_err}), 128'(3'b100));
    model_on = 1;

    // R2: 16 lanes x 8 bytes straddling two lines
    for (int i = 0; i < 32; i++) a[i] = 32'(192 + 8 * i);
    run("R2", 2'd0, 1'b0, 3'd3, 32'h0000_FFFF, 2);
    // R2: whole warp x 4 bytes in one line
    for (int i = 0; i < 32; i++) a[i] = 32'(1024 + 4 * i);
    run("R2", 2'd0, 1'b0, 3'd2, 32'hFFFF_FFFF, 1);
    // R3: the same pattern uncached splits into four segments
    run("R3", 2'd0, 1'b1, 3'd2, 32'hFFFF_FFFF, 4);
    // R4: order by lowest lane per line
    clear_addr();
    a[0] = 32'h1000; a[1] = 32'h80; a[2] = 32'h1004; a[3] = 32'h2000;
    run("R4", 2'd0, 1'b0, 3'd2, 32'h0000_000F, 3);
    // R5: 16-byte accesses filling a line, and sparse single bytes
    for (int i = 0; i < 32; i++) a[i] = 32'(256 + 16 * i);
    run("R5", 2'd0, 1'b0, 3'd4, 32'h0000_00FF, 1);
    clear_addr();
    a[0] = 32'h305; a[4] = 32'h37F; a[9] = 32'h300; a[20] = 32'h341;
    run("R5", 2'd0, 1'b0, 3'd0, 32'h0010_0211, 1);
    // R6: all lanes loading one address
    for (int i = 0; i < 32; i++) a[i] = 32'h40;
    run("R6", 2'd0, 1'b0, 3'd2, 32'hFFFF_FFFF, 1);
    // R7: stores, lanes 3,7,9 collide, lane 5 separate address in the line
    clear_addr();
    a[3] = 32'h200; a[7] = 32'h200; a[9] = 32'h200; a[5] = 32'h208;
    run("R7", 2'd1, 1'b0, 3'd3, 32'h0000_02A8, 1);
    // R8: atomics never merge
    clear_addr();
    a[0] = 32'h300; a[1] = 32'h300; a[2] = 32'h300; a[4] = 32'h304;
    run("R8", 2'd2, 1'b0, 3'd2, 32'h0000_0017, 4);
    // R9: empty mask, then only inactive lanes with scattered addresses
    run("R9", 2'd0, 1'b0, 3'd2, 32'h0, 0);
    for (int i = 0; i < 32; i++) a[i] = 32'(4096 * i);
    run("R9", 2'd0, 1'b0, 3'd2, 32'h0000_0001, 1);
    // R10: lane 0 misaligned, lane 1 kept
    clear_addr();
    a[0] = 32'h2; a[1] = 32'h4;
    run("R10", 2'd0, 1'b0, 3'd2, 32'h0000_0003, 1);
    check("R10", seen_err == 32'h1, "align_err_lanes seen", 128'(seen_err), 128'(1));
    // R11: stalled downstream, uncached stores over many segments
    stall_mode = 1;
    for (int i = 0; i < 32; i++) a[i] = 32'(8 * i);
    run("R11", 2'd1, 1'b1, 3'd3, 32'hFFFF_FFFF, 8);
    run("R11", 2'd3, 1'b0, 3'd1, 32'h0000_F00F, 8);
    stall_mode = 0;

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog %s run did not finish actual=hung expected=done", tag);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule